// File: doc/BRIEF.md
# Reconfigurable Test Register (Generator / Compactor / Scan / Load)

This block is an N-bit register that serves a self-test controller in four ways, chosen by a two-bit mode input. As a plain register it captures parallel data. As a scan segment it shifts serially from `scan_in` toward `scan_out`, which is how a seed is loaded and how a finished signature is unloaded. As a pseudorandom source it steps a maximal-length sequence defined by a primitive polynomial. As a multiple-input signature register it folds up to N parallel response bits into its state on every clock.

The feedback is internal: the most significant stage is fed back through an XOR placed in front of every stage whose polynomial coefficient is one. The polynomial is a build parameter that includes its constant and leading terms. When the block is built with M < N data inputs, only stages 0..M-1 receive a data XOR; the upper N-M stages carry none.

Top module: `tr_bilbo`

## Requirements
- R1: A synchronous active-high reset loads the parameter `SEED` (default 8'h01) into the state on the next clock edge.
- R2: Mode 2'b00 (load): on each clock, stage i takes `din[i]` for i < M, and stages M..N-1 take 0.
- R3: Mode 2'b01 (scan): on each clock, stage 0 takes `scan_in` and stage i takes stage i-1; no feedback is applied.
- R4: Mode 2'b10 (generate) with the default polynomial x^8+x^4+x^3+x^2+1 (`POLY` = 9'h11D) steps through all 255 non-zero states and returns to its start after exactly 255 clocks.
- R5: In mode 2'b10, `din` has no effect on the state sequence.
- R6: Mode 2'b11 (signature): the next state is the generate-mode next state (shift toward the MSB; if the old MSB was 1, XOR with `POLY[N-1:0]`) XOR the zero-extended `din`.
- R7: Stages M..N-1 have no data input: in mode 2'b11 from the all-zero state the next state equals `din` with bits M..N-1 zero, and from 8'h80 with `din`=6'h3F the next state is 8'h22.
- R8: In mode 2'b10 the all-zero state persists, and any non-zero state never steps to zero.
- R9: `scan_out` always shows the MSB of the state, so after N scan clocks a loaded value leaves MSB first.
- R10: `state` always shows the full register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 load, 01 scan, 10 generate, 11 signature |
| din | input | M | Parallel data / response inputs |
| scan_in | input | 1 | Serial input into stage 0 |
| scan_out | output | 1 | Serial output, MSB of the state |
| state | output | N | Parallel register contents |

## Verification
The hardest situation to reach is the signature step where the feedback bit and the data bits both land on the same stages, because the MSB must be exactly 1 while a chosen data word is applied. The bench gets there by shifting the value 8'h80 in through the scan path and then switching to signature mode for a single clock. The full generator period is covered by running 255 generate clocks from the reset seed and tracking every visited state, and the ignored-data rule by driving changing `din` throughout generate mode.

// File: rtl/tr_bilbo_pkg.sv
package tr_bilbo_pkg;
  typedef enum logic [1:0] {
    MODE_LOAD = 2'b00,
    MODE_SCAN = 2'b01,
    MODE_GEN  = 2'b10,
    MODE_SIG  = 2'b11
  } tr_mode_e;

  typedef struct packed {
    logic load;
    logic scan;
    logic step;
    logic fold;
  } tr_ctl_t;
endpackage

// File: rtl/tr_mode_dec.sv
module tr_mode_dec
  import tr_bilbo_pkg::*;
(
  input  logic [1:0] mode,
  output tr_ctl_t    ctl
);
  always_comb begin
    ctl = '0;
    unique case (tr_mode_e'(mode))
      MODE_LOAD: ctl.load = 1'b1;
      MODE_SCAN: ctl.scan = 1'b1;
      MODE_GEN:  ctl.step = 1'b1;
      MODE_SIG:  begin
        ctl.step = 1'b1;
        ctl.fold = 1'b1;
      end
      default:   ctl = '0;
    endcase
  end
endmodule

// File: rtl/tr_stage.sv
module tr_stage
  import tr_bilbo_pkg::*;
#(
  parameter bit HAS_TAP  = 1'b0,
  parameter bit HAS_DATA = 1'b0,
  parameter bit INIT     = 1'b0
)(
  input  logic    clk,
  input  logic    rst,
  input  tr_ctl_t ctl,
  input  logic    shift_bit,
  input  logic    chain_bit,
  input  logic    fb_bit,
  input  logic    data_bit,
  output logic    q
);
  logic tap_term;
  logic data_term;
  logic lfsr_d;
  logic nxt;

  generate
    if (HAS_TAP) begin : g_tap
      assign tap_term = fb_bit;
    end else begin : g_notap
      assign tap_term = 1'b0 & fb_bit;
    end
    if (HAS_DATA) begin : g_data
      assign data_term = data_bit & ctl.fold;
    end else begin : g_nodata
      assign data_term = 1'b0 & data_bit;
    end
  endgenerate

  assign lfsr_d = chain_bit ^ tap_term ^ data_term;

  always_comb begin
    nxt = q;
    if (ctl.load)      nxt = HAS_DATA ? data_bit : 1'b0;
    else if (ctl.scan) nxt = shift_bit;
    else if (ctl.step) nxt = lfsr_d;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= INIT;
    else     q <= nxt;
  end
endmodule

// File: rtl/tr_bilbo.sv
module tr_bilbo
  import tr_bilbo_pkg::*;
#(
  parameter int           N    = 8,
  parameter int           M    = 6,
  parameter logic [N:0]   POLY = 9'h11D,
  parameter logic [N-1:0] SEED = 8'h01
)(
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic [M-1:0] din,
  input  logic         scan_in,
  output logic         scan_out,
  output logic [N-1:0] state
);
  localparam int MSB = N - 1;

  tr_ctl_t    ctl;
  logic [N-1:0] q;
  logic         fb;

  tr_mode_dec u_dec (.mode(mode), .ctl(ctl));

  assign fb = q[MSB];

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic shift_b;
    logic chain_b;
    logic data_b;
    if (i == 0) begin : g_first
      assign shift_b = scan_in;
      assign chain_b = 1'b0;
    end else begin : g_rest
      assign shift_b = q[i-1];
      assign chain_b = q[i-1];
    end
    if (i < M) begin : g_din
      assign data_b = din[i];
    end else begin : g_nodin
      assign data_b = 1'b0;
    end
    tr_stage #(
      .HAS_TAP (POLY[i]),
      .HAS_DATA(i < M),
      .INIT    (SEED[i])
    ) u_st (
      .clk      (clk),
      .rst      (rst),
      .ctl      (ctl),
      .shift_bit(shift_b),
      .chain_bit(chain_b),
      .fb_bit   (fb),
      .data_bit (data_b),
      .q        (q[i])
    );
  end

  assign state    = q;
  assign scan_out = q[MSB];
endmodule

// File: rtl/tr_bilbo_chk.sv
module tr_bilbo_chk #(
  parameter int           N    = 8,
  parameter int           M    = 6,
  parameter logic [N-1:0] SEED = 8'h01
)(
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode,
  input logic [M-1:0] din,
  input logic         scan_in,
  input logic         scan_out,
  input logic [N-1:0] state
);
  a_r1_reset_seed: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> state == SEED);

  a_r2_load_low: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b00 |=> state[M-1:0] == $past(din));

  if (M < N) begin : g_upper
    a_r2_load_upper: assert property (@(posedge clk) disable iff (rst)
      mode == 2'b00 |=> state[N-1:M] == '0);
  end

  a_r3_scan_shift: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b01 |=> state == {$past(state[N-2:0]), $past(scan_in)});

  a_r8_no_lockin: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && state != '0) |=> state != '0);

  a_r8_zero_stays: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && state == '0) |=> state == '0);

  a_r6_sig_stage0: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b11 |=> state[0] == ($past(state[N-1]) ^ $past(din[0])));

  a_r9_scan_out: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b01 |=> scan_out == $past(state[N-2]));
endmodule

bind tr_bilbo tr_bilbo_chk #(.N(N), .M(M), .SEED(SEED)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .din(din),
  .scan_in(scan_in), .scan_out(scan_out), .state(state)
);

// File: tb/sim_tr_bilbo.sv
module sim_tr_bilbo;
  localparam int           N    = 8;
  localparam int           M    = 6;
  localparam logic [N:0]   POLY = 9'h11D;
  localparam logic [N-1:0] SEED = 8'h01;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic [M-1:0] din = '0;
  logic         scan_in = 1'b0;
  logic         scan_out;
  logic [N-1:0] state;
  logic [N-1:0] ref_q;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tr_bilbo #(.N(N), .M(M), .POLY(POLY), .SEED(SEED)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .din(din),
    .scan_in(scan_in), .scan_out(scan_out), .state(state)
  );

  function automatic logic [N-1:0] ref_next(logic [N-1:0] s, logic [1:0] m,
                                            logic [M-1:0] d, logic si);
    logic [N-1:0] r;
    r = '0;
    case (m)
      2'b00: r[M-1:0] = d;
      2'b01: r = {s[N-2:0], si};
      default: begin
        r = s << 1;
        if (s[N-1]) r = r ^ POLY[N-1:0];
        if (m == 2'b11) r[M-1:0] = r[M-1:0] ^ d;
      end
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) ref_q <= SEED;
    else     ref_q <= ref_next(ref_q, mode, din, scan_in);
  end

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic [1:0] m, logic [M-1:0] d, logic si, string req);
    mode = m; din = d; scan_in = si;
    @(negedge clk);
    chk(req, state, ref_q);
    chk({req, " scan_out R9"}, N'(scan_out), N'(ref_q[N-1]));
  endtask

  task automatic scan_word(logic [N-1:0] w);
    for (int k = N - 1; k >= 0; k--) cyc(2'b01, '0, w[k], "R3 scan");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [255:0] seen;
    int distinct;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R1 reset seed", state, SEED);
    chk("R10 state vs model", state, ref_q);

    // R2 load, upper stages cleared
    cyc(2'b00, 6'h3F, 1'b0, "R2 load");
    chk("R2 load 3F", state, 8'h3F);
    cyc(2'b00, 6'h15, 1'b1, "R2 load");
    chk("R2 load 15", state, 8'h15);

    // R3 scan in a seed
    scan_word(8'hA5);
    chk("R3 scan seed A5", state, 8'hA5);

    // R9 shift out MSB first
    scan_word(8'hC3);
    for (int k = N - 1; k >= 0; k--) begin
      chk("R9 scan_out bit", N'(scan_out), N'(bit'(8'hC3 >> k)));
      cyc(2'b01, '0, 1'b0, "R9 unload");
    end

    // R4 full period from reset seed
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 reset again", state, SEED);
    seen = '0; seen[SEED] = 1'b1; distinct = 1;
    for (int k = 1; k <= 255; k++) begin
      cyc(2'b10, '0, 1'b0, "R4 generate");
      if (k < 255) begin
        if (!seen[state]) distinct++;
        seen[state] = 1'b1;
      end
    end
    chk("R4 back to start after 255", state, SEED);
    chk("R4 distinct states", N'(distinct), N'(255));
    chk("R8 zero never visited", N'(seen[0]), N'(0));

    // R5 generate ignores din
    scan_word(8'h5A);
    for (int k = 0; k < 40; k++)
      cyc(2'b10, M'(k * 13 + 7), k[0], "R5 din ignored");

    // R6 signature compaction
    cyc(2'b00, '0, 1'b0, "R6 clear");
    for (int k = 0; k < 60; k++)
      cyc(2'b11, M'(k * 29 + 3), 1'b0, "R6 signature");

    // R7 upper stages have no data
    cyc(2'b00, '0, 1'b0, "R7 clear");
    cyc(2'b11, 6'h3F, 1'b0, "R7 from zero");
    chk("R7 from zero", state, 8'h3F);
    scan_word(8'h80);
    cyc(2'b11, 6'h3F, 1'b0, "R7 from 80");
    chk("R7 from 80", state, 8'h22);

    // R8 all-zero lock in generate mode
    cyc(2'b00, '0, 1'b0, "R8 clear");
    for (int k = 0; k < 20; k++) cyc(2'b10, 6'h2A, 1'b1, "R8 zero");
    chk("R8 zero stays", state, '0);

    finish_run();
  end
endmodule